// File: doc/BRIEF.md
# Linear and Table-Driven Frequency Ramp Sequencer

This block produces, on every modulator clock, the fractional division ratio that a sigma-delta modulator consumes during a frequency sweep. In counter mode an accumulator starts at a programmed ratio and adds a fixed increment each cycle. The result is an exactly linear ramp with nothing superimposed on it.

In table mode the ramp shape comes from an external synchronous-read memory, so nearly any curve can be swept. Memory words are fetched at one quarter of the output rate. The three output values between neighbouring stored words are rebuilt by linear interpolation, so a sweep needs only a quarter as many stored words as output points. The next word is fetched ahead of need, so a read latency of one or two cycles never leaves a gap in the output.

A start pulse samples the mode, start ratio, increment and length. The ramp then runs for the programmed number of output values, or until a stop pulse, and afterwards holds its last value.

Top module: `ramp_seq`

## Requirements
- R1: After reset, ratio_vld is 0, ratio is 0 and mem_rd is 0.
- R2: In counter mode (mode=0), a start pulse with len not equal to 0 gives ratio_vld=1 and ratio=start_ratio in the cycle after the start edge.
- R3: In counter mode, each further valid cycle shows the previous ratio plus incr. The increment is taken as two's complement and the sum wraps modulo 2^RW. The values of mode, start_ratio, incr and len are sampled only at the start edge.
- R4: A ramp gives exactly len contiguous valid cycles. After that, ratio_vld is 0 and ratio holds the last value until the next start.
- R5: In table mode (mode=1), output value n equals S[k] + floor(j*(S[k+1]-S[k])/4) modulo 2^RW. Here k=n>>2, j=n&3, S[i] is the memory word at address i, and the difference is signed.
- R6: In table mode, with a memory read latency of RD_LAT (1 or 2) cycles, the len valid outputs come with no gap once the first one appears.
- R7: Table mode reads addresses 0, 1, 2, ... in order. A run reads exactly 2+ceil(len/4) words, and while running it never issues reads in two consecutive cycles.
- R8: A stop pulse during a ramp drops ratio_vld in the next cycle, and ratio keeps the value shown in the cycle stop was high.
- R9: A start pulse with len=0 is ignored: ratio_vld stays 0 and ratio is unchanged.
- R10: A start pulse during a running ramp restarts it at once with the newly sampled settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, samples the settings |
| stop | input | 1 | Ends the ramp, output holds |
| mode | input | 1 | 0 = counter ramp, 1 = table ramp |
| start_ratio | input | RW | Initial ratio in counter mode |
| incr | input | RW | Per-cycle increment, two's complement |
| len | input | LW | Number of output values |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | AW | Memory word address |
| mem_data | input | RW | Memory read data, RD_LAT cycles after request |
| ratio | output | RW | Division ratio to the modulator |
| ratio_vld | output | 1 | High on every cycle of a running ramp |

## Verification
A corrupt segment register shows up at the ports within four output values. The interpolated values then stop landing on stored words at every fourth point, or the step sizes inside a segment no longer match. A fetch that is late or lost shows as a gap in ratio_vld or as a wrong next segment. The bench catches this by comparing every output value and by counting read requests and addresses. A counter or length fault is seen in the last cycle of a ramp, where the count of valid cycles and the held value are both checked.

// File: rtl/ramp_seq.sv
module ramp_seq #(
  parameter int RW = 24,
  parameter int LW = 16,
  parameter int AW = 8,
  parameter int RD_LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          stop,
  input  logic          mode,
  input  logic [RW-1:0] start_ratio,
  input  logic [RW-1:0] incr,
  input  logic [LW-1:0] len,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [RW-1:0] mem_data,
  output logic [RW-1:0] ratio,
  output logic          ratio_vld
);
  typedef enum logic [1:0] {S_IDLE, S_PRIME, S_RUN} st_t;

  st_t st;
  logic mode_q, got;
  logic [RW-1:0] inc_q, acc, cur, nxt, pend, interp;
  logic [LW-1:0] len_q, cnt;
  logic [1:0] ph, iss;
  logic [AW-1:0] raddr;
  logic [RD_LAT-1:0] rd_pipe;
  logic signed [RW:0] d;
  logic signed [RW+2:0] dx, prod;

  wire go   = start && (len != '0);
  wire cap  = rd_pipe[RD_LAT-1];
  wire last = (cnt == len_q - LW'(1));

  assign mem_rd    = (st == S_PRIME && iss != 2'd2) || (st == S_RUN && mode_q && ph == 2'd0);
  assign mem_addr  = raddr;
  assign ratio_vld = (st == S_RUN);

  assign d  = $signed({1'b0, nxt}) - $signed({1'b0, cur});
  assign dx = {{2{d[RW]}}, d};
  always_comb begin
    case (ph)
      2'd0:    prod = '0;
      2'd1:    prod = dx;
      2'd2:    prod = dx <<< 1;
      default: prod = dx + (dx <<< 1);
    endcase
  end
  assign interp = cur + RW'(prod >>> 2);
  assign ratio  = mode_q ? interp : acc;

  always_ff @(posedge clk) begin
    if (!rst_n || go) rd_pipe <= '0;
    else begin
      rd_pipe[0] <= mem_rd;
      for (int i = 1; i < RD_LAT; i++) rd_pipe[i] <= rd_pipe[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; mode_q <= 1'b0; got <= 1'b0;
      inc_q <= '0; acc <= '0; cur <= '0; nxt <= '0; pend <= '0;
      len_q <= '0; cnt <= '0; ph <= '0; iss <= '0; raddr <= '0;
    end else if (go) begin
      mode_q <= mode; inc_q <= incr; len_q <= len; acc <= start_ratio;
      cnt <= '0; ph <= '0; iss <= '0; raddr <= '0; got <= 1'b0;
      st <= mode ? S_PRIME : S_RUN;
    end else if (stop) begin
      st <= S_IDLE;
    end else begin
      case (st)
        S_PRIME: begin
          if (mem_rd) begin
            raddr <= raddr + AW'(1);
            iss   <= iss + 2'd1;
          end
          if (cap) begin
            nxt <= mem_data;
            if (!got) got <= 1'b1;
            else begin
              cur <= nxt;
              st  <= S_RUN;
            end
          end
        end
        S_RUN: begin
          if (mem_rd) raddr <= raddr + AW'(1);
          if (cap) pend <= mem_data;
          if (last) st <= S_IDLE;
          else begin
            cnt <= cnt + LW'(1);
            ph  <= ph + 2'd1;
            acc <= acc + inc_q;
            if (ph == 2'd3) begin
              cur <= nxt;
              nxt <= pend;
            end
          end
        end
        default: ;
      endcase
    end
  end

  p_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ratio_vld) && !mode_q |-> ratio == $past(start_ratio));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_vld && $past(ratio_vld) && !mode_q && !$past(start) |-> ratio == $past(ratio) + inc_q);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE && $past(st == S_IDLE) |-> $stable(ratio));

  p_rdrate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_RUN && mem_rd && !start |=> !mem_rd);

  p_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop) && !$past(start) |-> !ratio_vld);
endmodule

// File: tb/ramp_seq_tb_top.sv
`timescale 1ns/1ps
module ramp_seq_tb_top;
  localparam int RW = 24, LW = 16, AW = 8, LAT = 2;
  localparam longint MASK = (64'sd1 <<< RW) - 1;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, stop = 1'b0, mode = 1'b0;
  logic [RW-1:0] start_ratio = '0, incr = '0, mem_data, ratio;
  logic [LW-1:0] len = '0;
  logic [AW-1:0] mem_addr;
  logic mem_rd, ratio_vld;
  logic [RW-1:0] mem [0:63];
  logic [RW-1:0] mq0, mq1;
  int total = 0, bad = 0, rd_seen = 0, addr_err = 0, exp_addr = 0;

  always #2 clk = ~clk;

  ramp_seq #(.RW(RW), .LW(LW), .AW(AW), .RD_LAT(LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .mode(mode),
    .start_ratio(start_ratio), .incr(incr), .len(len), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_data(mem_data), .ratio(ratio), .ratio_vld(ratio_vld));

  always @(posedge clk) begin
    if (mem_rd) mq0 <= mem[mem_addr[5:0]];
    mq1 <= mq0;
  end
  assign mem_data = mq1;

  always @(posedge clk) begin
    if (rst_n && mem_rd) begin
      if (int'(mem_addr) != exp_addr) addr_err++;
      exp_addr++;
      rd_seen++;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic longint ref_tbl(input int n);
    longint a, b, p;
    a = longint'(mem[n >> 2]);
    b = longint'(mem[(n >> 2) + 1]);
    p = longint'(n & 3) * (b - a);
    p = p >>> 2;
    return (a + p) & MASK;
  endfunction

  task automatic kick(input bit m, input longint sr, input longint inc, input int l);
    @(negedge clk);
    mode = m; start_ratio = RW'(sr & MASK); incr = RW'(inc & MASK); len = LW'(l); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic t_reset();
    chk(!ratio_vld, "R1 vld", longint'(ratio_vld), 0);
    chk(ratio == '0, "R1 ratio", longint'(ratio), 0);
    chk(!mem_rd, "R1 mem_rd", longint'(mem_rd), 0);
  endtask

  task automatic t_counter(input longint sr, input longint inc, input int l);
    longint e;
    kick(1'b0, sr, inc, l);
    for (int n = 0; n < l; n++) begin
      e = (sr + n * inc) & MASK;
      chk(ratio_vld && longint'(ratio) == e, (n == 0) ? "R2 first" : "R3 step", longint'(ratio), e);
      @(negedge clk);
    end
    e = (sr + (l - 1) * inc) & MASK;
    for (int w = 0; w < 3; w++) begin
      chk(!ratio_vld && longint'(ratio) == e, "R4 end hold", longint'(ratio), e);
      @(negedge clk);
    end
  endtask

  task automatic t_table(input int l);
    int w = 0;
    exp_addr = 0; rd_seen = 0; addr_err = 0;
    kick(1'b1, 0, 0, l);
    while (!ratio_vld && w < 20) begin
      @(negedge clk);
      w++;
    end
    for (int n = 0; n < l; n++) begin
      chk(ratio_vld, "R6 no gap", longint'(ratio_vld), 1);
      chk(longint'(ratio) == ref_tbl(n), "R5 interp", longint'(ratio), ref_tbl(n));
      @(negedge clk);
    end
    chk(!ratio_vld && longint'(ratio) == ref_tbl(l - 1), "R4 table hold", longint'(ratio), ref_tbl(l - 1));
    chk(rd_seen == 2 + (l + 3) / 4, "R7 read count", rd_seen, 2 + (l + 3) / 4);
    chk(addr_err == 0, "R7 address order", addr_err, 0);
  endtask

  task automatic t_stop();
    longint sr = 24'h012345, inc = 77;
    kick(1'b0, sr, inc, 20);
    for (int n = 0; n < 5; n++) begin
      chk(ratio_vld && longint'(ratio) == ((sr + n * inc) & MASK), "R8 pre-stop", longint'(ratio), (sr + n * inc) & MASK);
      if (n < 4) @(negedge clk);
    end
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk(!ratio_vld, "R8 vld low", longint'(ratio_vld), 0);
    chk(longint'(ratio) == ((sr + 4 * inc) & MASK), "R8 held", longint'(ratio), (sr + 4 * inc) & MASK);
  endtask

  task automatic t_len0();
    longint r0 = longint'(ratio);
    kick(1'b0, 123, 1, 0);
    for (int w = 0; w < 3; w++) begin
      chk(!ratio_vld && longint'(ratio) == r0, "R9 ignored", longint'(ratio), r0);
      @(negedge clk);
    end
  endtask

  task automatic t_restart();
    longint s1 = 1000, s2 = 24'hABC000, i2 = 5;
    kick(1'b0, s1, 10, 30);
    for (int n = 0; n < 3; n++) begin
      chk(longint'(ratio) == s1 + n * 10, "R10 first ramp", longint'(ratio), s1 + n * 10);
      if (n < 2) @(negedge clk);
    end
    start_ratio = RW'(s2); incr = RW'(i2); len = LW'(4); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n < 4; n++) begin
      chk(ratio_vld && longint'(ratio) == s2 + n * i2, "R10 restarted", longint'(ratio), s2 + n * i2);
      @(negedge clk);
    end
    chk(!ratio_vld, "R10 new length", longint'(ratio_vld), 0);
  endtask

  initial begin
    #(4 * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++)
      mem[i] = RW'((longint'(24'h200000) + i * 40503 - (i % 3) * 90001) & MASK);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_counter(24'h100000, 3, 9);
    t_counter(10, -3, 6);
    t_table(10);
    t_table(13);
    t_table(4);
    t_stop();
    t_len0();
    t_restart();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule